// File: doc/BRIEF.md
# Single-Bus Processor Datapath with Step Sequencer

This block is a tiny processor core in which every transfer between internal registers goes over one shared internal bus. It has a program counter, a memory address register, a memory data register that loads from memory or from the bus, an instruction register, four general-purpose registers and an adder. The adder has an operand-hold register A and a result-hold register C. Because only one value can be on the bus in a cycle, each addition is spread over three bus cycles. A step sequencer drives a one-hot bus source select and the load enables of every register. It moves through the micro-steps of instruction fetch, load, store and register add, one step per clock.

After reset the core is idle and the program counter is zero. A one-cycle pulse on `go` starts execution at the current program counter. The core then runs instructions until it fetches a HALT. `busy` is high for the whole run. Memory is an external synchronous port: read data is returned one cycle after `mem_rd`, and the memory takes a write on the clock edge while `mem_wr` is high. The instruction word is 16 bits: opcode in bits 15:12, register field in bits 11:10, address field in bits 9:0. Opcodes are 0 = ADD, 1 = ST, 2 = LD, F = HALT. Each instruction occupies one word.

States and transitions:
- IDLE goes to F_ADDR on `go`.
- The fetch chain is F_ADDR (PC onto the bus, into MAR), then F_READ (read strobe), then F_CAPT (read word into MDR), then F_IR (MDR onto the bus, into IR), then PC_INC.
- PC_INC dispatches: ADD goes to ADD_A, ST goes to ST_ADDR, LD goes to LD_ADDR, HALT goes to IDLE, and any other opcode goes back to F_ADDR.
- ADD runs ADD_A (second source into A), then ADD_C (A plus destination into C), then ADD_WB (C into the destination).
- ST runs ST_ADDR (address field into MAR over the direct path), then ST_DATA (register over the bus into MDR), then ST_WRITE.
- LD runs LD_ADDR, then LD_READ, then LD_CAPT, then LD_WB.
- ADD_WB, ST_WRITE and LD_WB each return to F_ADDR.

Top module: `cpu_bus_datapath`

## Requirements
- R1: After reset `busy`, `mem_rd` and `mem_wr` are low, and the first `go` fetches from address 0.
- R2: Fetch puts the program counter on `mem_addr` with `mem_rd` high in the second cycle after the `go` edge, and in the second cycle of every later fetch.
- R3: The program counter advances by one after each fetch, so instructions run from consecutive addresses.
- R4: LD (opcode 2) loads the register named in bits 11:10 from the memory word at the address in bits 9:0.
- R5: ST (opcode 1) issues exactly one `mem_wr` cycle, with `mem_addr` equal to bits 9:0 and `mem_wdata` equal to the register named in bits 11:10.
- R6: ADD (opcode 0) sets the register in bits 11:10 to its old value plus the register named by bits 1:0, modulo 2^16. When both fields name the same register, its value doubles.
- R7: HALT (opcode F) ends the run. `busy` goes low and there is no memory access while idle. The next `go` resumes at the word after the HALT.
- R8: Any other opcode only costs the fetch. It causes no write and no register change.
- R9: At most one source drives the internal bus in any cycle.
- R10: `busy` lasts exactly 5 cycles per HALT or unused opcode, 8 per ADD or ST and 9 per LD. A `go` pulse during a run has no effect.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse, taken only while idle |
| busy | output | 1 | High while instructions are running |
| mem_addr | output | 10 | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe; data is due one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, driven from the data register |
| mem_rdata | input | 16 | Read data from memory |

## Verification
The register file can only be seen through ST instructions, and ADD reads two register fields in sequence through the A register. The hardest case to reach is therefore a wrong operand order or a wrong register select inside an add. The stimulus runs a generated program for every pairing of destination and second source, including self-addition. Each program first loads all four registers with distinct values, some of them chosen to wrap. It then stores all four registers back, so every register is compared against the sum the bench computes. A resume program placed after each HALT shows that the program counter kept its place.

// File: rtl/cpu_dp_pkg.sv
package cpu_dp_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OP_ADD  = 4'h0;
    localparam logic [OPC_W-1:0] OP_ST   = 4'h1;
    localparam logic [OPC_W-1:0] OP_LD   = 4'h2;
    localparam logic [OPC_W-1:0] OP_HALT = 4'hF;

    // bus source positions in the one-hot select
    localparam int BUS_SRCS = 4;
    localparam int SRC_PC   = 0;
    localparam int SRC_MDR  = 1;
    localparam int SRC_GPR  = 2;
    localparam int SRC_C    = 3;

    typedef enum logic [3:0] {
        S_IDLE, S_F_ADDR, S_F_READ, S_F_CAPT, S_F_IR, S_PC_INC,
        S_ADD_A, S_ADD_C, S_ADD_WB,
        S_ST_ADDR, S_ST_DATA, S_ST_WRITE,
        S_LD_ADDR, S_LD_READ, S_LD_CAPT, S_LD_WB
    } seq_state_t;

    typedef struct packed {
        logic [BUS_SRCS-1:0] bus_sel;
        logic                mar_from_bus;
        logic                mar_from_ir;
        logic                mdr_from_mem;
        logic                mdr_from_bus;
        logic                ir_load;
        logic                pc_inc;
        logic                a_load;
        logic                c_load;
        logic                gpr_write;
        logic                gpr_sel_src2;
        logic                mem_rd;
        logic                mem_wr;
        logic                busy;
    } ctrl_t;

endpackage

// File: rtl/cpu_dp_seq.sv
module cpu_dp_seq
    import cpu_dp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [OPC_W-1:0] opcode,
    output ctrl_t            ctrl
);

    seq_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (go) state_nx = S_F_ADDR;
            S_F_ADDR:   state_nx = S_F_READ;
            S_F_READ:   state_nx = S_F_CAPT;
            S_F_CAPT:   state_nx = S_F_IR;
            S_F_IR:     state_nx = S_PC_INC;
            S_PC_INC: begin
                if      (opcode == OP_ADD)  state_nx = S_ADD_A;
                else if (opcode == OP_ST)   state_nx = S_ST_ADDR;
                else if (opcode == OP_LD)   state_nx = S_LD_ADDR;
                else if (opcode == OP_HALT) state_nx = S_IDLE;
                else                        state_nx = S_F_ADDR;
            end
            S_ADD_A:    state_nx = S_ADD_C;
            S_ADD_C:    state_nx = S_ADD_WB;
            S_ADD_WB:   state_nx = S_F_ADDR;
            S_ST_ADDR:  state_nx = S_ST_DATA;
            S_ST_DATA:  state_nx = S_ST_WRITE;
            S_ST_WRITE: state_nx = S_F_ADDR;
            S_LD_ADDR:  state_nx = S_LD_READ;
            S_LD_READ:  state_nx = S_LD_CAPT;
            S_LD_CAPT:  state_nx = S_LD_WB;
            S_LD_WB:    state_nx = S_F_ADDR;
            default:    state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        ctrl      = '0;
        ctrl.busy = (state != S_IDLE);
        unique case (state)
            S_IDLE:     ;
            S_F_ADDR:   begin ctrl.bus_sel[SRC_PC]  = 1'b1; ctrl.mar_from_bus = 1'b1; end
            S_F_READ:   ctrl.mem_rd = 1'b1;
            S_F_CAPT:   ctrl.mdr_from_mem = 1'b1;
            S_F_IR:     begin ctrl.bus_sel[SRC_MDR] = 1'b1; ctrl.ir_load = 1'b1; end
            S_PC_INC:   ctrl.pc_inc = 1'b1;
            S_ADD_A:    begin ctrl.bus_sel[SRC_GPR] = 1'b1; ctrl.gpr_sel_src2 = 1'b1; ctrl.a_load = 1'b1; end
            S_ADD_C:    begin ctrl.bus_sel[SRC_GPR] = 1'b1; ctrl.c_load = 1'b1; end
            S_ADD_WB:   begin ctrl.bus_sel[SRC_C]   = 1'b1; ctrl.gpr_write = 1'b1; end
            S_ST_ADDR:  ctrl.mar_from_ir = 1'b1;
            S_ST_DATA:  begin ctrl.bus_sel[SRC_GPR] = 1'b1; ctrl.mdr_from_bus = 1'b1; end
            S_ST_WRITE: ctrl.mem_wr = 1'b1;
            S_LD_ADDR:  ctrl.mar_from_ir = 1'b1;
            S_LD_READ:  ctrl.mem_rd = 1'b1;
            S_LD_CAPT:  ctrl.mdr_from_mem = 1'b1;
            S_LD_WB:    begin ctrl.bus_sel[SRC_MDR] = 1'b1; ctrl.gpr_write = 1'b1; end
            default:    ;
        endcase
    end

    assert_bus_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctrl.bus_sel));

    assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.mem_rd && ctrl.mem_wr));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.busy |-> !(ctrl.mem_rd || ctrl.mem_wr));

    assert_write_after_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.mem_wr |-> $past(ctrl.mdr_from_bus));

endmodule

// File: rtl/cpu_dp_gpr.sv
module cpu_dp_gpr #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 4,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REG_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                           regs[g] <= '0;
            else if (we && waddr == REG_W'(g))    regs[g] <= wdata;
        end
    end

    assign rdata = regs[raddr];

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && raddr == waddr) |=> rdata == $past(wdata));

endmodule

// File: rtl/cpu_dp_alu.sv
module cpu_dp_alu #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_load,
    input  logic              c_load,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] c_out
);

    logic [DATA_W-1:0] a_hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_hold <= '0;
            c_out  <= '0;
        end else begin
            if (a_load) a_hold <= bus_in;
            if (c_load) c_out  <= a_hold + bus_in;
        end
    end

    assert_a_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !a_load |=> $stable(a_hold));

endmodule

// File: rtl/cpu_bus_datapath.sv
module cpu_bus_datapath
    import cpu_dp_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 4
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          go,
    output logic                                          busy,
    output logic [DATA_W-OPC_W-$clog2(NUM_REGS)-1:0]      mem_addr,
    output logic                                          mem_rd,
    output logic                                          mem_wr,
    output logic [DATA_W-1:0]                             mem_wdata,
    input  logic [DATA_W-1:0]                             mem_rdata
);

    localparam int REG_W  = $clog2(NUM_REGS);
    localparam int ADDR_W = DATA_W - OPC_W - REG_W;

    ctrl_t             ctrl;
    logic [ADDR_W-1:0] pc, mar;
    logic [DATA_W-1:0] mdr, ir, bus, gpr_rd, c_val;
    logic [DATA_W-1:0] bus_src [BUS_SRCS];

    wire [OPC_W-1:0]  ir_op   = ir[DATA_W-1 -: OPC_W];
    wire [REG_W-1:0]  ir_reg  = ir[ADDR_W +: REG_W];
    wire [ADDR_W-1:0] ir_addr = ir[ADDR_W-1:0];
    wire [REG_W-1:0]  gpr_ra  = ctrl.gpr_sel_src2 ? ir[REG_W-1:0] : ir_reg;

    cpu_dp_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .opcode (ir_op),
        .ctrl   (ctrl)
    );

    cpu_dp_gpr #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_gpr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl.gpr_write),
        .waddr (ir_reg),
        .wdata (bus),
        .raddr (gpr_ra),
        .rdata (gpr_rd)
    );

    cpu_dp_alu #(.DATA_W(DATA_W)) u_alu (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_load (ctrl.a_load),
        .c_load (ctrl.c_load),
        .bus_in (bus),
        .c_out  (c_val)
    );

    // shared internal bus: AND-OR of the one-hot selected source
    assign bus_src[SRC_PC]  = {{(DATA_W-ADDR_W){1'b0}}, pc};
    assign bus_src[SRC_MDR] = mdr;
    assign bus_src[SRC_GPR] = gpr_rd;
    assign bus_src[SRC_C]   = c_val;

    always_comb begin
        bus = '0;
        for (int i = 0; i < BUS_SRCS; i++)
            bus = bus | (bus_src[i] & {DATA_W{ctrl.bus_sel[i]}});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= '0;
            mar <= '0;
            mdr <= '0;
            ir  <= '0;
        end else begin
            if (ctrl.pc_inc)            pc  <= pc + 1'b1;
            if (ctrl.mar_from_bus)      mar <= bus[ADDR_W-1:0];
            else if (ctrl.mar_from_ir)  mar <= ir_addr;
            if (ctrl.mdr_from_mem)      mdr <= mem_rdata;
            else if (ctrl.mdr_from_bus) mdr <= bus;
            if (ctrl.ir_load)           ir  <= bus;
        end
    end

    assign busy      = ctrl.busy;
    assign mem_addr  = mar;
    assign mem_rd    = ctrl.mem_rd;
    assign mem_wr    = ctrl.mem_wr;
    assign mem_wdata = mdr;

    assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.pc_inc |=> pc == $past(pc) + 1'b1);

    assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.pc_inc |=> $stable(pc));

    assert_mdr_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.mdr_from_mem |=> mdr == $past(mem_rdata));

    assert_store_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> mem_addr == ir_addr);

endmodule

// File: tb/tb_cpu_bus_datapath.sv
module tb_cpu_bus_datapath;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        busy, mem_rd, mem_wr;
    logic [9:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    logic        tb_we = 1'b0;
    logic [9:0]  tb_addr = '0;
    logic [15:0] tb_data = '0;
    logic [15:0] mem [1024];

    int n_checks = 0, n_fail = 0, wr_count = 0, cyc = 0, conflicts = 0;

    always #4 clk = ~clk;

    cpu_bus_datapath dut (
        .clk(clk), .rst_n(rst_n), .go(go), .busy(busy),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (tb_we)       mem[tb_addr] <= tb_data;
        else if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    always @(negedge clk) begin
        cyc++;
        if (mem_wr) wr_count++;
        if (mem_rd && mem_wr) conflicts++;
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [1:0] r, input logic [9:0] a);
        return {op, r, a};
    endfunction

    task automatic poke(input logic [9:0] a, input logic [15:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = a; tb_data = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // pulse go, count busy cycles, note the first read
    task automatic run(input int mid_go, output int n, output int rd_cyc, output logic [9:0] rd_addr);
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        n = 0; rd_cyc = -1; rd_addr = '0;
        while (busy && n < 2000) begin
            n++;
            if (mem_rd && rd_cyc < 0) begin rd_cyc = n; rd_addr = mem_addr; end
            go = (mid_go != 0 && n == mid_go);
            @(negedge clk);
        end
        go = 1'b0;
    endtask

    initial begin
        int n, rc, w0;
        logic [9:0] ra;
        logic [15:0] v [4];

        // R1: reset state
        do_reset();
        repeat (2) @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 mem_rd after reset", mem_rd, 0);
        chk("R1 mem_wr after reset", mem_wr, 0);

        for (int t = 0; t < 4; t++) begin
            for (int rd = 0; rd < 4; rd++) begin
                for (int src = 0; src < 4; src++) begin
                    for (int i = 0; i < 4; i++) begin
                        if (t == 0) v[i] = (i == 0) ? 16'hFFFF : (i == 1) ? 16'h0001 : (i == 2) ? 16'h8000 : 16'h7FFF;
                        else        v[i] = 16'(t * 16'h3A7B + i * 16'h1111 + rd * 16'h0303 + src * 16'h0071 + 16'h0F0F);
                        poke(10'(800 + i), v[i]);
                        poke(10'(900 + i), 16'hDEAD);
                        poke(10'(i), enc(4'h2, 2'(i), 10'(800 + i)));
                        poke(10'(5 + i), enc(4'h1, 2'(i), 10'(900 + i)));
                    end
                    poke(10'd4, enc(4'h0, 2'(rd), 10'(src)));
                    poke(10'd9, enc(4'hF, 2'd0, 10'd0));
                    poke(10'd10, enc(4'h1, 2'(rd), 10'd950));
                    poke(10'd11, enc(4'hF, 2'd0, 10'd0));
                    poke(10'd950, 16'hDEAD);
                    v[rd] = v[rd] + v[src];

                    do_reset();
                    run(0, n, rc, ra);
                    chk("R10 busy cycles LDx4 ADD STx4 HALT", n, 81);
                    chk("R2 first read cycle", rc, 2);
                    chk("R1 first fetch address", ra, 0);
                    for (int i = 0; i < 4; i++)
                        chk((i == rd) ? "R6 add result" : "R4 loaded register", mem[900 + i], v[i]);

                    // R7: idle after halt is quiet
                    w0 = wr_count;
                    repeat (5) @(negedge clk);
                    chk("R7 busy low after halt", busy, 0);
                    chk("R7 no write while idle", wr_count - w0, 0);

                    run(0, n, rc, ra);
                    chk("R7 resume address", ra, 10);
                    chk("R5 store after resume", mem[950], v[rd]);
                    chk("R10 busy cycles ST HALT", n, 13);
                end
            end
        end

        // R8 unused opcodes, R10 go ignored while busy
        poke(10'd800, 16'h5A5A);
        poke(10'd900, 16'h1234);
        poke(10'd901, 16'h0000);
        poke(10'd0, enc(4'h2, 2'd1, 10'd800));
        poke(10'd1, enc(4'h3, 2'd1, 10'd900));
        poke(10'd2, enc(4'h7, 2'd1, 10'd900));
        poke(10'd3, enc(4'h1, 2'd1, 10'd901));
        poke(10'd4, enc(4'hF, 2'd0, 10'd0));
        do_reset();
        w0 = wr_count;
        run(12, n, rc, ra);
        chk("R10 cycles with unused opcodes and mid-run go", n, 32);
        chk("R8 single write only", wr_count - w0, 1);
        chk("R8 untouched word", mem[900], 16'h1234);
        chk("R8 register unchanged", mem[901], 16'h5A5A);
        repeat (5) @(negedge clk);
        chk("R10 mid-run go did not restart", busy, 0);
        chk("R11 read/write overlap count", conflicts, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule